// File: doc/BRIEF.md
# Transaction Status and Verification Unit

This block is the per-core controller for a hardware memory transaction. It keeps two status flags. The first, `active_o`, shows that a transaction is open. The second, `clean_o`, shows that the open transaction has not yet lost a conflict. There is no begin instruction: the first transactional memory access from the core opens a transaction. While a transaction is open, the unit watches one or more snoop channels and the bus response path. A remote write to a line the core has read, any remote access to a line the core has written, or a BUSY reply to a transactional bus request marks the transaction as failed. A failed transaction keeps running until its next verification instruction.

The core issues three verification instructions: check, finish and drop. The unit answers each one with a registered result strobe and a success bit. In the same cycle it sends the transactional cache a one-cycle pulse. A commit pulse makes the tentative lines permanent. A discard pulse throws them away. A failed check, every finish and every drop leave the flags idle (`active_o` = 0, `clean_o` = 1). An interrupt has the same effect as a drop.

Top module: `txn_status_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `active_o` is 0, `clean_o` is 1, and `result_valid_o`, `commit_o` and `discard_o` are 0.
- R2: A cycle with `txn_access_i` high and no verification instruction or interrupt sets `active_o` in the next cycle. `clean_o` keeps its value.
- R3: While `active_o` is 1, a snoop channel with its valid bit set makes `clean_o` 0 in the next cycle if it reports either of two events: a remote write (`snp_write_i` = 1) to a read-set line, or any remote access to a write-set line. A remote read of a line that is only in the read set has no effect. Snoops have no effect while `active_o` is 0.
- R4: While `active_o` is 1, a cycle with `bus_busy_i` high makes `clean_o` 0 in the next cycle.
- R5: Check (`op_code_i` = 2'b01) returns ok equal to `clean_o`. A conflict arriving in the same cycle counts against the check. A passing check leaves the flags unchanged and sends no pulse. A failing check sends a discard and leaves the flags idle.
- R6: Finish (`op_code_i` = 2'b10) uses `clean_o` as it stood before the instruction. If clean, it sends a commit pulse and returns ok = 1. Otherwise it sends a discard pulse and returns ok = 0. A conflict in the same cycle is ignored. Either way the flags end idle.
- R7: Drop (`op_code_i` = 2'b11) always sends a discard pulse, returns ok = 0 and leaves the flags idle.
- R8: An interrupt (`irq_i`) sends a discard pulse and leaves the flags idle. It takes priority over any instruction in the same cycle. That instruction still gets a result strobe, with ok = 0, and never produces a commit.
- R9: The result strobe and any commit or discard pulse appear in the cycle after the instruction is sampled and last exactly one cycle. Commit and discard are never high together.
- R10: `op_valid_i` with `op_code_i` = 2'b00 is ignored: no result strobe, no pulse, and no change to the flags.
- R11: After a conflict, further transactional accesses keep `active_o` at 1, and `clean_o` stays 0 until a verification instruction or an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_access_i | input | 1 | Transactional load or store issued this cycle |
| bus_busy_i | input | 1 | BUSY reply to a transactional bus request |
| snp_valid_i | input | PORTS | Snoop event valid, one bit per channel |
| snp_write_i | input | PORTS | Snooped access is a write |
| snp_in_rd_i | input | PORTS | Snooped line is in the read set |
| snp_in_wr_i | input | PORTS | Snooped line is in the write set |
| op_valid_i | input | 1 | Verification instruction issued |
| op_code_i | input | 2 | 01 check, 10 finish, 11 drop, 00 none |
| irq_i | input | 1 | Interrupt; forces a discard |
| result_valid_o | output | 1 | Instruction result strobe |
| result_ok_o | output | 1 | Instruction success bit |
| commit_o | output | 1 | One-cycle commit pulse to the transactional cache |
| discard_o | output | 1 | One-cycle discard pulse to the transactional cache |
| active_o | output | 1 | Transaction-open flag |
| clean_o | output | 1 | No-conflict flag |

## Verification
The bench targets conflicts that arrive in the same cycle as an instruction. Check must see such a conflict and finish must not. A design that resolves this the other way either lets a stale check pass or throws away a valid commit. The bench also sends a remote read to a line that is only in the read set. A design that treats every snoop hit as a conflict aborts such transactions for no reason. Snoops while idle, orphaned transactions that keep issuing accesses, and an interrupt that collides with a finish are each covered too. A wrong design in these cases would leave stale flags, re-arm `clean_o`, or commit data that should have been discarded.

// File: rtl/txn_pkg.sv
package txn_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_CHECK  = 2'b01,
    OP_FINISH = 2'b10,
    OP_DROP   = 2'b11
  } txn_op_e;

  typedef struct packed {
    logic live;
    logic clean;
  } txn_flags_t;

  typedef struct packed {
    logic rvalid;
    logic rok;
    logic commit;
    logic discard;
  } txn_resp_t;

  localparam txn_flags_t FLAGS_IDLE = '{live: 1'b0, clean: 1'b1};
  localparam txn_resp_t  RESP_NONE  = '{rvalid: 1'b0, rok: 1'b0, commit: 1'b0, discard: 1'b0};

endpackage

// File: rtl/txn_conflict_detect.sv
module txn_conflict_detect #(
  parameter int PORTS = 2
) (
  input  logic [PORTS-1:0] snp_valid_i,
  input  logic [PORTS-1:0] snp_write_i,
  input  logic [PORTS-1:0] snp_in_rd_i,
  input  logic [PORTS-1:0] snp_in_wr_i,
  input  logic             bus_busy_i,
  output logic             lost_o
);

  logic [PORTS-1:0] hit;

  // One detector per snoop channel
  for (genvar p = 0; p < PORTS; p++) begin : g_chan
    always_comb begin
      hit[p] = snp_valid_i[p] &
               ((snp_write_i[p] & snp_in_rd_i[p]) | snp_in_wr_i[p]);
    end
  end

  always_comb begin
    lost_o = (|hit) | bus_busy_i;
  end

endmodule

// File: rtl/txn_verify_decode.sv
module txn_verify_decode
  import txn_pkg::*;
(
  input  txn_flags_t flags_q,
  input  logic       txn_access_i,
  input  logic       lost_i,
  input  logic       op_valid_i,
  input  logic [1:0] op_code_i,
  input  logic       irq_i,
  output txn_flags_t flags_n,
  output txn_resp_t  resp_n
);

  txn_op_e    op;
  logic       op_live;
  logic       lost_eff;
  txn_flags_t run_flags;

  always_comb begin
    op       = txn_op_e'(op_code_i);
    op_live  = op_valid_i & (op != OP_NONE);
    lost_eff = flags_q.live & lost_i;
    // Flag update when no instruction completes this cycle
    run_flags.live  = flags_q.live | txn_access_i;
    run_flags.clean = flags_q.clean & ~lost_eff;
  end

  always_comb begin
    flags_n = run_flags;
    resp_n  = RESP_NONE;
    if (irq_i) begin
      flags_n        = FLAGS_IDLE;
      resp_n.discard = 1'b1;
      resp_n.rvalid  = op_live;
      resp_n.rok     = 1'b0;
    end else if (op_live) begin
      resp_n.rvalid = 1'b1;
      unique case (op)
        OP_CHECK: begin
          resp_n.rok = run_flags.clean;
          if (!run_flags.clean) begin
            resp_n.discard = 1'b1;
            flags_n        = FLAGS_IDLE;
          end
        end
        OP_FINISH: begin
          resp_n.rok     = flags_q.clean;
          resp_n.commit  = flags_q.clean;
          resp_n.discard = ~flags_q.clean;
          flags_n        = FLAGS_IDLE;
        end
        OP_DROP: begin
          resp_n.discard = 1'b1;
          flags_n        = FLAGS_IDLE;
        end
        default: begin
          resp_n = RESP_NONE;
        end
      endcase
    end
  end

endmodule

// File: rtl/txn_flag_regs.sv
module txn_flag_regs
  import txn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  txn_flags_t flags_n,
  input  txn_resp_t  resp_n,
  output txn_flags_t flags_q,
  output txn_resp_t  resp_q
);

  logic flags_en;

  always_comb begin
    flags_en = (flags_n != flags_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= FLAGS_IDLE;
    end else if (flags_en) begin
      flags_q <= flags_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= RESP_NONE;
    end else begin
      resp_q <= resp_n;
    end
  end

endmodule

// File: rtl/txn_status_unit.sv
module txn_status_unit
  import txn_pkg::*;
#(
  parameter int PORTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_access_i,
  input  logic             bus_busy_i,
  input  logic [PORTS-1:0] snp_valid_i,
  input  logic [PORTS-1:0] snp_write_i,
  input  logic [PORTS-1:0] snp_in_rd_i,
  input  logic [PORTS-1:0] snp_in_wr_i,
  input  logic             op_valid_i,
  input  logic [1:0]       op_code_i,
  input  logic             irq_i,
  output logic             result_valid_o,
  output logic             result_ok_o,
  output logic             commit_o,
  output logic             discard_o,
  output logic             active_o,
  output logic             clean_o
);

  logic       lost;
  txn_flags_t flags_q;
  txn_flags_t flags_n;
  txn_resp_t  resp_n;
  txn_resp_t  resp_q;

  txn_conflict_detect #(.PORTS(PORTS)) u_detect (
    .snp_valid_i (snp_valid_i),
    .snp_write_i (snp_write_i),
    .snp_in_rd_i (snp_in_rd_i),
    .snp_in_wr_i (snp_in_wr_i),
    .bus_busy_i  (bus_busy_i),
    .lost_o      (lost)
  );

  txn_verify_decode u_decode (
    .flags_q      (flags_q),
    .txn_access_i (txn_access_i),
    .lost_i       (lost),
    .op_valid_i   (op_valid_i),
    .op_code_i    (op_code_i),
    .irq_i        (irq_i),
    .flags_n      (flags_n),
    .resp_n       (resp_n)
  );

  txn_flag_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_n (flags_n),
    .resp_n  (resp_n),
    .flags_q (flags_q),
    .resp_q  (resp_q)
  );

  always_comb begin
    active_o       = flags_q.live;
    clean_o        = flags_q.clean;
    result_valid_o = resp_q.rvalid;
    result_ok_o    = resp_q.rok;
    commit_o       = resp_q.commit;
    discard_o      = resp_q.discard;
  end

endmodule

// File: rtl/txn_status_chk.sv
module txn_status_chk #(
  parameter int PORTS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txn_access_i,
  input logic             bus_busy_i,
  input logic [PORTS-1:0] snp_valid_i,
  input logic [PORTS-1:0] snp_write_i,
  input logic [PORTS-1:0] snp_in_rd_i,
  input logic [PORTS-1:0] snp_in_wr_i,
  input logic             op_valid_i,
  input logic [1:0]       op_code_i,
  input logic             irq_i,
  input logic             result_valid_o,
  input logic             result_ok_o,
  input logic             commit_o,
  input logic             discard_o,
  input logic             active_o,
  input logic             clean_o
);

  logic any_op;
  logic snoop_conflict;

  always_comb begin
    any_op         = op_valid_i && (op_code_i != 2'b00);
    snoop_conflict = |(snp_valid_i & ((snp_write_i & snp_in_rd_i) | snp_in_wr_i));
  end

  // R9: pulses are exclusive
  a_r9_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_o && discard_o));

  // R6: a commit only comes with a successful result
  a_r6_commit_has_ok: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (result_valid_o && result_ok_o));

  // R6: after a commit the flags are idle
  a_r6_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (!active_o && clean_o));

  // R3: a conflicting snoop on an open transaction clears the clean flag
  a_r3_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && snoop_conflict && !any_op && !irq_i) |=> !clean_o);

  // R4: BUSY reply on an open transaction clears the clean flag
  a_r4_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && bus_busy_i && !any_op && !irq_i) |=> !clean_o);

  // R8: interrupt always produces a discard and never a commit
  a_r8_irq_discards: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |=> (discard_o && !commit_o && !active_o));

  // R10: a no-op instruction yields no result
  a_r10_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_op && !irq_i) |=> (!result_valid_o && !discard_o && !commit_o));

  // R11: clean flag never re-arms while a transaction stays open
  a_r11_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !clean_o && !any_op && !irq_i) |=> (active_o && !clean_o));

endmodule

bind txn_status_unit txn_status_chk #(.PORTS(PORTS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .txn_access_i   (txn_access_i),
  .bus_busy_i     (bus_busy_i),
  .snp_valid_i    (snp_valid_i),
  .snp_write_i    (snp_write_i),
  .snp_in_rd_i    (snp_in_rd_i),
  .snp_in_wr_i    (snp_in_wr_i),
  .op_valid_i     (op_valid_i),
  .op_code_i      (op_code_i),
  .irq_i          (irq_i),
  .result_valid_o (result_valid_o),
  .result_ok_o    (result_ok_o),
  .commit_o       (commit_o),
  .discard_o      (discard_o),
  .active_o       (active_o),
  .clean_o        (clean_o)
);

// File: tb/sim_txn_status_unit.sv
`timescale 1ns/1ps
module sim_txn_status_unit;

  localparam int PORTS = 2;

  logic             clk;
  logic             rst_n;
  logic             txn_access_i;
  logic             bus_busy_i;
  logic [PORTS-1:0] snp_valid_i;
  logic [PORTS-1:0] snp_write_i;
  logic [PORTS-1:0] snp_in_rd_i;
  logic [PORTS-1:0] snp_in_wr_i;
  logic             op_valid_i;
  logic [1:0]       op_code_i;
  logic             irq_i;
  logic             result_valid_o;
  logic             result_ok_o;
  logic             commit_o;
  logic             discard_o;
  logic             active_o;
  logic             clean_o;

  int checks;
  int errors;

  txn_status_unit #(.PORTS(PORTS)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .txn_access_i   (txn_access_i),
    .bus_busy_i     (bus_busy_i),
    .snp_valid_i    (snp_valid_i),
    .snp_write_i    (snp_write_i),
    .snp_in_rd_i    (snp_in_rd_i),
    .snp_in_wr_i    (snp_in_wr_i),
    .op_valid_i     (op_valid_i),
    .op_code_i      (op_code_i),
    .irq_i          (irq_i),
    .result_valid_o (result_valid_o),
    .result_ok_o    (result_ok_o),
    .commit_o       (commit_o),
    .discard_o      (discard_o),
    .active_o       (active_o),
    .clean_o        (clean_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    txn_access_i = 1'b0;
    bus_busy_i   = 1'b0;
    snp_valid_i  = '0;
    snp_write_i  = '0;
    snp_in_rd_i  = '0;
    snp_in_wr_i  = '0;
    op_valid_i   = 1'b0;
    op_code_i    = 2'b00;
    irq_i        = 1'b0;
  endtask

  // Apply current inputs for one edge, then return them to idle
  task automatic step();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic open_txn();
    txn_access_i = 1'b1;
    step();
  endtask

  task automatic expect_resp(input string req, input logic rv, input logic ok,
                             input logic cm, input logic dc, input logic act, input logic cl);
    chk(req, "result_valid", result_valid_o, rv);
    chk(req, "result_ok",    result_ok_o,    ok);
    chk(req, "commit",       commit_o,       cm);
    chk(req, "discard",      discard_o,      dc);
    chk(req, "active",       active_o,       act);
    chk(req, "clean",        clean_o,        cl);
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    expect_resp("R1", 0, 0, 0, 0, 0, 1);
    rst_n = 1'b1;
    step();
    expect_resp("R1", 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_open_and_nop();
    open_txn();
    expect_resp("R2", 0, 0, 0, 0, 1, 1);
    op_valid_i = 1'b1; op_code_i = 2'b00;
    step();
    expect_resp("R10", 0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_commit_ok();
    op_valid_i = 1'b1; op_code_i = 2'b10;
    step();
    expect_resp("R6", 1, 1, 1, 0, 0, 1);
    step();
    expect_resp("R9", 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_read_set_conflict();
    open_txn();
    snp_valid_i[0] = 1'b1; snp_write_i[0] = 1'b0; snp_in_rd_i[0] = 1'b1;
    step();
    chk("R3", "clean after remote read of read-set line", clean_o, 1'b1);
    snp_valid_i[1] = 1'b1; snp_write_i[1] = 1'b1; snp_in_rd_i[1] = 1'b1;
    step();
    chk("R3", "clean after remote write to read-set line", clean_o, 1'b0);
    txn_access_i = 1'b1;
    step();
    step();
    chk("R11", "active of orphan", active_o, 1'b1);
    chk("R11", "clean of orphan", clean_o, 1'b0);
    op_valid_i = 1'b1; op_code_i = 2'b01;
    step();
    expect_resp("R5", 1, 0, 0, 1, 0, 1);
  endtask

  task automatic t_write_set_read();
    open_txn();
    snp_valid_i[0] = 1'b1; snp_write_i[0] = 1'b0; snp_in_wr_i[0] = 1'b1;
    step();
    chk("R3", "clean after remote read of write-set line", clean_o, 1'b0);
    op_valid_i = 1'b1; op_code_i = 2'b10;
    step();
    expect_resp("R6", 1, 0, 0, 1, 0, 1);
  endtask

  task automatic t_idle_snoop();
    snp_valid_i = '1; snp_write_i = '1; snp_in_rd_i = '1; snp_in_wr_i = '1;
    step();
    expect_resp("R3", 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_busy_then_drop();
    open_txn();
    bus_busy_i = 1'b1;
    step();
    chk("R4", "clean after BUSY", clean_o, 1'b0);
    op_valid_i = 1'b1; op_code_i = 2'b11;
    step();
    expect_resp("R7", 1, 0, 0, 1, 0, 1);
  endtask

  task automatic t_check_pass_and_race();
    open_txn();
    op_valid_i = 1'b1; op_code_i = 2'b01;
    step();
    expect_resp("R5", 1, 1, 0, 0, 1, 1);
    op_valid_i = 1'b1; op_code_i = 2'b01;
    snp_valid_i[1] = 1'b1; snp_write_i[1] = 1'b1; snp_in_wr_i[1] = 1'b1;
    step();
    expect_resp("R5", 1, 0, 0, 1, 0, 1);
  endtask

  task automatic t_commit_race();
    open_txn();
    op_valid_i = 1'b1; op_code_i = 2'b10;
    snp_valid_i[0] = 1'b1; snp_write_i[0] = 1'b1; snp_in_rd_i[0] = 1'b1;
    step();
    expect_resp("R6", 1, 1, 1, 0, 0, 1);
  endtask

  task automatic t_drop_clean();
    open_txn();
    op_valid_i = 1'b1; op_code_i = 2'b11;
    step();
    expect_resp("R7", 1, 0, 0, 1, 0, 1);
  endtask

  task automatic t_irq();
    open_txn();
    irq_i = 1'b1;
    step();
    expect_resp("R8", 0, 0, 0, 1, 0, 1);
    open_txn();
    irq_i = 1'b1; op_valid_i = 1'b1; op_code_i = 2'b10;
    step();
    expect_resp("R8", 1, 0, 0, 1, 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    t_open_and_nop();
    t_commit_ok();
    t_read_set_conflict();
    t_write_set_read();
    t_idle_snoop();
    t_busy_then_drop();
    t_check_pass_and_race();
    t_commit_race();
    t_drop_clean();
    t_irq();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule